// File: doc/BRIEF.md
# Latching Pulse-Loss Fault Monitor

This block supervises a periodic pulse stream, such as a fan tachometer signal or a processor heartbeat. It measures the gap between successive rising edges in clock cycles. When a gap runs past a programmable maximum, it drives an active-low fault/reset output. After power-up the block moves through four phases:

- a reset hold, during which the output is held low;
- a blanking window, during which a slow or silent source is tolerated while it spins up;
- an unarmed watch phase, during which a missing pulse gives only a short fixed-length low pulse;
- an armed phase, during which a missing pulse latches the output low.

The latch is released only by a power-on reset or by a synchronous clear input.

The phase lengths are elaboration parameters. The blanking window must end before arming, and the reset hold may not outlast the blanking window. A configuration that breaks this ordering is rejected at elaboration. The maximum period is a run-time input and can be changed at any time. The power-on reset is asynchronous and is released through a two-stage synchroniser. The pulse input is also brought in through a two-flop synchroniser.

Top module: `pulse_loss_monitor`

## Requirements
- R1: `fault_n` is low while `por_n` is low, and for `HOLD_CYCLES` cycles after the internal release of reset. The internal release comes two clock edges after `por_n` rises.
- R2: From the end of the hold until `BLANK_CYCLES` after release, no missing pulse can drive `fault_n` low.
- R3: Each rising edge of `pulse_in`, seen after two synchroniser flops, restarts the gap count at zero. A stream whose edges come no more than `max_period` cycles apart never causes a fault.
- R4: Once monitoring is active, a gap count reaching `max_period` with no edge in that cycle is a time-out. The count then restarts from zero.
- R5: A time-out before `ARM_CYCLES` after release drives `fault_n` low for exactly `PULSE_LEN` cycles, after which it returns high without latching.
- R6: A time-out at or after `ARM_CYCLES` latches `fault_n` low. It stays low even when pulses resume.
- R7: A high `fault_clr` sampled on a clock edge releases the latch and any pending pulse, so `fault_n` is high after that edge. While `fault_clr` is high, it also suppresses time-outs.
- R8: Taking `por_n` low clears the latch. The full start-up sequence then repeats.
- R9: A change of `max_period` during operation takes effect on the next comparison. Shortening it below the actual pulse spacing produces a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pulse_in | input | 1 | Monitored pulse stream (asynchronous) |
| fault_clr | input | 1 | Synchronous clear of the latched fault, active high |
| max_period | input | CNT_W | Longest allowed gap between rising edges, in cycles |
| fault_n | output | 1 | Active-low fault/reset output |

## Verification
The hardest case to reach is a time-out that lands exactly around the arming boundary. Under that condition, the same missing pulse yields either a fixed pulse or a latch. The stimulus first leaves the source silent through the unarmed watch phase, producing repeated fixed pulses. It then drives a steady in-spec pulse train across the arm point and stops it only after arming, so both outcomes are observed in one start-up. A behavioural model tracks elapsed cycles, the gap count and the pulse countdown with plain integers. The model is compared with `fault_n` every cycle through clears, period changes and a second power-on reset.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Start-up phase of the monitor, in order of occurrence.
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_BLANK = 2'd1,
    PH_WATCH = 2'd2,
    PH_ARMED = 2'd3
  } plm_phase_e;

endpackage

// File: rtl/plm_rst_sync.sv
module plm_rst_sync (
  input  logic clk,
  input  logic por_n,
  output logic rst_n
);

  logic stage1_q;
  logic stage2_q;

  // Asynchronous assertion, synchronous release after two edges (R1).
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n = stage2_q;

endmodule

// File: rtl/plm_edge_sync.sv
module plm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);

  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // Rising edge of the synchronised input (R3).
  assign rise = sync_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);  // R3

endmodule

// File: rtl/plm_startup.sv
module plm_startup
  import plm_pkg::*;
#(
  parameter int HOLD_CYCLES  = 20,
  parameter int BLANK_CYCLES = 60,
  parameter int ARM_CYCLES   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  output plm_phase_e phase
);

  localparam int T_W = $clog2(ARM_CYCLES + 1);
  localparam logic [T_W-1:0] HOLD_T  = T_W'(HOLD_CYCLES);
  localparam logic [T_W-1:0] BLANK_T = T_W'(BLANK_CYCLES);
  localparam logic [T_W-1:0] ARM_T   = T_W'(ARM_CYCLES);

  logic [T_W-1:0] elapsed_q, elapsed_d;
  logic           elapsed_en;

  // Saturating count of cycles since reset release.
  always_comb begin
    elapsed_en = (elapsed_q != ARM_T);
    elapsed_d  = elapsed_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (elapsed_en) begin
      elapsed_q <= elapsed_d;
    end
  end

  // Phase decode: hold, blanking, unarmed watch, armed (R1, R2, R5, R6).
  always_comb begin
    if (elapsed_q < HOLD_T) begin
      phase = PH_HOLD;
    end else if (elapsed_q < BLANK_T) begin
      phase = PH_BLANK;
    end else if (elapsed_q < ARM_T) begin
      phase = PH_WATCH;
    end else begin
      phase = PH_ARMED;
    end
  end

  AST_ELAPSED_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> elapsed_q >= $past(elapsed_q));  // R1

  AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ARMED |=> phase == PH_ARMED);  // R6

endmodule

// File: rtl/plm_gap_timer.sv
module plm_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             rise,
  input  logic             clr,
  input  logic [CNT_W-1:0] max_period,
  output logic             timeout
);

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             expired;

  always_comb begin
    expired = (gap_q >= max_period);
    timeout = mon_en & ~rise & ~clr & expired;
    if (!mon_en || rise || clr || expired) begin
      gap_d = '0;
    end else begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_d;
    end
  end

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> gap_q == '0);  // R3

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(max_period) && ($past(gap_q) <= max_period)) |-> gap_q <= max_period);  // R4

  AST_QUIET_UNMONITORED: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> gap_q == '0);  // R2

endmodule

// File: rtl/plm_fault_out.sv
module plm_fault_out #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic armed,
  input  logic hold,
  input  logic clr,
  output logic fault_n
);

  localparam int P_W = $clog2(PULSE_LEN + 1);
  localparam logic [P_W-1:0] PULSE_LOAD = P_W'(PULSE_LEN);

  logic           latched_q, latched_d;
  logic [P_W-1:0] pulse_q, pulse_d;

  always_comb begin
    latched_d = latched_q;
    pulse_d   = pulse_q;
    if (clr) begin
      latched_d = 1'b0;
      pulse_d   = '0;
    end else if (timeout && armed) begin
      latched_d = 1'b1;
    end else if (timeout) begin
      pulse_d = PULSE_LOAD;
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      pulse_q   <= '0;
    end else begin
      latched_q <= latched_d;
      pulse_q   <= pulse_d;
    end
  end

  assign fault_n = ~(hold | latched_q | (pulse_q != '0));

  AST_LATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_q) |-> $past(armed));  // R6

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !clr) |=> latched_q);  // R6

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!latched_q && pulse_q == '0));  // R7

  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !timeout && !clr) |=> pulse_q == $past(pulse_q) - 1'b1);  // R5

endmodule

// File: rtl/pulse_loss_monitor.sv
module pulse_loss_monitor
  import plm_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int HOLD_CYCLES  = 20,
  parameter int BLANK_CYCLES = 60,
  parameter int ARM_CYCLES   = 200,
  parameter int PULSE_LEN    = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pulse_in,
  input  logic             fault_clr,
  input  logic [CNT_W-1:0] max_period,
  output logic             fault_n
);

  // Phase ordering is part of the contract: blanking ends before arming.
  generate
    if (BLANK_CYCLES >= ARM_CYCLES || HOLD_CYCLES > BLANK_CYCLES) begin : g_bad_order
      $error("pulse_loss_monitor: need HOLD_CYCLES <= BLANK_CYCLES < ARM_CYCLES");
    end
  endgenerate

  logic       rst_n;
  logic       rise;
  logic       timeout;
  logic       mon_en;
  logic       armed;
  logic       hold;
  plm_phase_e phase;

  plm_rst_sync i_rst_sync (
    .clk   (clk),
    .por_n (por_n),
    .rst_n (rst_n)
  );

  plm_edge_sync i_edge_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (pulse_in),
    .rise  (rise)
  );

  plm_startup #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES),
    .ARM_CYCLES   (ARM_CYCLES)
  ) i_startup (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  always_comb begin
    hold   = (phase == PH_HOLD);
    mon_en = (phase == PH_WATCH) || (phase == PH_ARMED);
    armed  = (phase == PH_ARMED);
  end

  plm_gap_timer #(
    .CNT_W (CNT_W)
  ) i_gap_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .rise       (rise),
    .clr        (fault_clr),
    .max_period (max_period),
    .timeout    (timeout)
  );

  plm_fault_out #(
    .PULSE_LEN (PULSE_LEN)
  ) i_fault_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .timeout (timeout),
    .armed   (armed),
    .hold    (hold),
    .clr     (fault_clr),
    .fault_n (fault_n)
  );

  AST_BLANK_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BLANK) |-> !timeout);  // R2

  AST_POR_LOW: assert property (@(posedge clk)
    !por_n |-> !fault_n);  // R8

endmodule

// File: tb/test_pulse_loss_monitor.sv
module test_pulse_loss_monitor;

  localparam int CNT_W = 16;
  localparam int HOLD  = 20;
  localparam int BLANK = 60;
  localparam int ARM   = 200;
  localparam int PLEN  = 8;

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic             fault_clr = 1'b0;
  logic [CNT_W-1:0] max_period = 16'd10;
  logic             fault_n;

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  pulse_loss_monitor #(
    .CNT_W (CNT_W), .HOLD_CYCLES (HOLD), .BLANK_CYCLES (BLANK),
    .ARM_CYCLES (ARM), .PULSE_LEN (PLEN)
  ) i_pulse_loss_monitor (
    .clk (clk), .por_n (por_n), .pulse_in (pulse_in),
    .fault_clr (fault_clr), .max_period (max_period), .fault_n (fault_n)
  );

  // Behavioural reference: integers for elapsed time, gap, latch, pulse.
  int rel_edges, since, gap, pulse_left;
  bit latch;
  bit hist[3];

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rel_edges = 0; since = 0; gap = 0; pulse_left = 0; latch = 0;
      hist[0] = 0; hist[1] = 0; hist[2] = 0;
    end else if (rel_edges < 2) begin
      rel_edges++;
    end else begin
      bit edge_seen, watching, tout;
      edge_seen = hist[1] && !hist[2];
      watching  = since >= BLANK;
      tout      = watching && !edge_seen && !fault_clr && gap >= int'(max_period);
      if (fault_clr) begin
        latch = 0; pulse_left = 0;
      end else if (tout && since >= ARM) begin
        latch = 1;
      end else if (tout) begin
        pulse_left = PLEN;
      end else if (pulse_left > 0) begin
        pulse_left--;
      end
      if (!watching || edge_seen || fault_clr || gap >= int'(max_period)) gap = 0;
      else gap++;
      if (since < ARM) since++;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pulse_in;
    end
  end

  function automatic bit expect_n();
    return !(since < HOLD || latch || pulse_left > 0);
  endfunction

  always @(negedge clk) begin
    #1;
    cycles++;
    if (cmp_on) begin
      vectors++;
      if (fault_n !== expect_n()) begin
        fails++;
        $display("FAIL %s cycle %0d: fault_n=%b expected %b", cur_req, cycles, fault_n, expect_n());
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    #2;
    vectors++;
    if (fault_n !== exp) begin
      fails++;
      $display("FAIL %s: fault_n=%b expected %b", req, fault_n, exp);
    end
  endtask

  // Rising edge every 'period' cycles, high for two cycles.
  task automatic pulses(input int period, input int count);
    for (int i = 0; i < count; i++) begin
      pulse_in = 1'b1; tick(2);
      pulse_in = 1'b0; tick(period - 2);
    end
  endtask

  task automatic power_up();
    por_n = 1'b0; tick(3);
    cur_req = "R1"; chk("R1 output low in reset", 1'b0);
    cmp_on = 1'b1;
    por_n = 1'b1;
  endtask

  initial begin
    power_up();
    tick(12); chk("R1 hold still active", 1'b0);
    cur_req = "R2";
    tick(30); chk("R2 no fault during blanking", 1'b1);
    cur_req = "R5";
    tick(100);  // silent source in unarmed watch phase: fixed pulses
    cur_req = "R3";
    pulses(6, 20);  // crosses the arm point with in-spec pulses
    chk("R3 in-spec stream no fault", 1'b1);
    cur_req = "R6";
    tick(25); chk("R6 latched after arm", 1'b0);
    pulses(6, 8); chk("R6 stays latched with pulses", 1'b0);
    cur_req = "R7";
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    chk("R7 clear releases latch", 1'b1);
    pulses(6, 10); chk("R7 healthy after clear", 1'b1);
    cur_req = "R4";
    pulses(14, 3); chk("R4 long gap latches", 1'b0);
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
    cur_req = "R9";
    pulses(6, 5); chk("R9 before change ok", 1'b1);
    max_period = 16'd4;
    pulses(6, 3); chk("R9 shorter limit faults", 1'b0);
    cur_req = "R8";
    max_period = 16'd10;
    power_up();
    tick(10); chk("R8 restart hold low", 1'b0);
    tick(40); chk("R8 latch gone after restart", 1'b1);
    tick(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule